// File: doc/BRIEF.md
# Sampled Power-Fail Interrupt Generator

This block gives a processor early warning that its supply is about to fail. It receives a synchronous flag from an external comparator. The flag is high while a monitored supply sits below its sense point. The block also receives a flag that says the main supply is good. It does not act on the comparator flag directly. It samples the flag once per slow sample tick, which is derived from the system clock. It raises the interrupt only after a fixed number of consecutive samples have shown the supply low, so short noise dips are filtered out.

Once the interrupt fires, the block drives an active-low pulse. The pulse ends on whichever of three events comes first: a fixed timeout, the monitored input recovering, or the main supply losing its good status. Nothing reaches the output while the main supply is not good. After a pulse that ended on the timeout, the block stays quiet until a sample has shown the input back above threshold.

At the default values and a 100 MHz clock, the sample period is about 33 µs. Three samples take about 100 µs. The timeout pulse lasts 250 µs.

Top module: `pwrfail_irq`

## Requirements
- R1: While the synchronous reset `rst` is high, and on the first cycle after it, `irq_n_o` is 1. Reset clears the sample divider, the consecutive-sample count and the pulse timer, and it arms the block.
- R2: `below_i` is sampled once every `TICK_DIV` clock cycles. The first sample is taken on the `TICK_DIV`-th rising edge after reset is released. An interrupt can only begin on the cycle after a sample edge.
- R3: With `supply_ok_i` high, the block is armed once `NEED_SAMPLES` consecutive samples all see `below_i` = 1. `irq_n_o` then goes low on the cycle after the last of those sample edges. With default 3 samples, this falls 2·TICK_DIV+1 to 3·TICK_DIV cycles after `below_i` rises.
- R4: A sample that sees `below_i` = 0 clears the consecutive count. Low dips that cover fewer than `NEED_SAMPLES` samples never cause a pulse.
- R5: If `below_i` and `supply_ok_i` stay high, the pulse lasts exactly `HOLD_CYC` cycles, and it never lasts longer.
- R6: During a pulse, `below_i` = 0 releases `irq_n_o` to 1 on the next cycle.
- R7: While `supply_ok_i` is 0, `irq_n_o` stays 1 and the consecutive count is held at zero. At power-up with `below_i` held high, a full-length timeout pulse follows the rise of `supply_ok_i`.
- R8: If `supply_ok_i` falls during a pulse, `irq_n_o` returns to 1 on the next cycle.
- R9: After a pulse, no new pulse starts until some sample has seen `below_i` = 0.
- R10: With `below_i` held at 0 from power-up, `irq_n_o` never goes low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| below_i | input | 1 | Monitored supply below sense point (synchronous) |
| supply_ok_i | input | 1 | Main supply good |
| irq_n_o | output | 1 | Power-fail interrupt, active low |

## Verification
The bound checker checks four things on every cycle:
- the idle output around reset;
- the one-cycle release when the input recovers or the main supply drops;
- the absence of any pulse while the main supply is bad;
- the upper bound on pulse length, and that every pulse begins right after a sample edge with the input low.

The bench scenarios are needed for the rest. These are the exact sample counting and noise rejection across several sample periods, the exact timeout length, the rearm rule after a timeout, and the quiet power-up with a healthy input. A reference model built from the requirements is compared cycle by cycle under random input runs.

// File: rtl/pfi_pkg.sv
package pfi_pkg;

    // Reason an active pulse is being terminated this cycle.
    typedef enum logic [1:0] {
        END_NONE    = 2'd0,
        END_TIMEOUT = 2'd1,
        END_RECOVER = 2'd2,
        END_SUPPLY  = 2'd3
    } pfi_end_e;

endpackage

// File: rtl/pfi_tick.sv
module pfi_tick #(
    parameter int TICK_DIV = 3333
) (
    input  logic clk,
    input  logic rst,
    output logic tick_o
);
    localparam int W = (TICK_DIV > 2) ? $clog2(TICK_DIV) : 1;

    typedef struct packed {
        logic [W-1:0] cnt;
    } tick_st_t;

    tick_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (st_q.cnt == W'(TICK_DIV - 1)) begin
            st_d.cnt = '0;
        end else begin
            st_d.cnt = st_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign tick_o = (st_q.cnt == W'(TICK_DIV - 1));
endmodule

// File: rtl/pfi_qual.sv
module pfi_qual #(
    parameter int NEED_SAMPLES = 3
) (
    input  logic clk,
    input  logic rst,
    input  logic tick_i,
    input  logic below_i,
    input  logic good_i,
    output logic fire_o
);
    localparam int CW = $clog2(NEED_SAMPLES + 1);

    typedef struct packed {
        logic [CW-1:0] cnt;
        logic          armed;
    } qual_st_t;

    qual_st_t st_d, st_q;
    logic     fire;

    always_comb begin
        st_d = st_q;
        fire = 1'b0;
        if (!good_i) begin
            st_d.cnt = '0;
        end else if (tick_i) begin
            if (below_i) begin
                if (st_q.cnt == CW'(NEED_SAMPLES - 1) && st_q.armed) begin
                    fire       = 1'b1;
                    st_d.armed = 1'b0;
                end
                if (st_q.cnt != CW'(NEED_SAMPLES)) begin
                    st_d.cnt = st_q.cnt + 1'b1;
                end
            end else begin
                st_d.cnt   = '0;
                st_d.armed = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q.cnt   <= '0;
            st_q.armed <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end

    assign fire_o = fire;
endmodule

// File: rtl/pfi_pulse.sv
module pfi_pulse
    import pfi_pkg::*;
#(
    parameter int HOLD_CYC = 25000
) (
    input  logic clk,
    input  logic rst,
    input  logic fire_i,
    input  logic below_i,
    input  logic good_i,
    output logic active_o
);
    localparam int TW = (HOLD_CYC > 2) ? $clog2(HOLD_CYC) : 1;

    typedef struct packed {
        logic          act;
        logic [TW-1:0] tmr;
    } pulse_st_t;

    pulse_st_t st_d, st_q;
    pfi_end_e  cause;

    always_comb begin
        st_d  = st_q;
        cause = END_NONE;
        if (st_q.act) begin
            if (!good_i) begin
                cause = END_SUPPLY;
            end else if (!below_i) begin
                cause = END_RECOVER;
            end else if (st_q.tmr == TW'(HOLD_CYC - 1)) begin
                cause = END_TIMEOUT;
            end
            if (cause != END_NONE) begin
                st_d.act = 1'b0;
                st_d.tmr = '0;
            end else begin
                st_d.tmr = st_q.tmr + 1'b1;
            end
        end else if (fire_i) begin
            st_d.act = 1'b1;
            st_d.tmr = '0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign active_o = st_q.act;
endmodule

// File: rtl/pwrfail_irq.sv
module pwrfail_irq #(
    parameter int TICK_DIV     = 3333,
    parameter int HOLD_CYC     = 25000,
    parameter int NEED_SAMPLES = 3
) (
    input  logic clk,
    input  logic rst,
    input  logic below_i,
    input  logic supply_ok_i,
    output logic irq_n_o
);
    logic tick;
    logic fire;
    logic active;

    pfi_tick #(.TICK_DIV(TICK_DIV)) u_tick (
        .clk    (clk),
        .rst    (rst),
        .tick_o (tick)
    );

    pfi_qual #(.NEED_SAMPLES(NEED_SAMPLES)) u_qual (
        .clk     (clk),
        .rst     (rst),
        .tick_i  (tick),
        .below_i (below_i),
        .good_i  (supply_ok_i),
        .fire_o  (fire)
    );

    pfi_pulse #(.HOLD_CYC(HOLD_CYC)) u_pulse (
        .clk      (clk),
        .rst      (rst),
        .fire_i   (fire),
        .below_i  (below_i),
        .good_i   (supply_ok_i),
        .active_o (active)
    );

    assign irq_n_o = ~active;
endmodule

// File: rtl/pwrfail_irq_chk.sv
module pwrfail_irq_chk #(
    parameter int HOLD_CYC = 25000
) (
    input logic clk,
    input logic rst,
    input logic below_i,
    input logic supply_ok_i,
    input logic irq_n_o,
    input logic tick
);
    localparam int LW = $clog2(HOLD_CYC + 1);

    logic [LW-1:0] low_run;

    always_ff @(posedge clk) begin
        if (rst) begin
            low_run <= '0;
        end else if (!irq_n_o) begin
            if (low_run != LW'(HOLD_CYC)) low_run <= low_run + 1'b1;
        end else begin
            low_run <= '0;
        end
    end

    p_idle_after_reset_r1: assert property (@(posedge clk) rst |=> irq_n_o);

    p_start_on_sample_r2: assert property (@(posedge clk) disable iff (rst)
        $fell(irq_n_o) |-> ($past(tick) && $past(below_i) && $past(supply_ok_i)));

    p_max_len_r5: assert property (@(posedge clk) disable iff (rst)
        !irq_n_o |-> (low_run < LW'(HOLD_CYC)));

    p_recover_release_r6: assert property (@(posedge clk) disable iff (rst)
        (!irq_n_o && !below_i) |=> irq_n_o);

    p_no_pulse_without_supply_r7: assert property (@(posedge clk) disable iff (rst)
        !supply_ok_i |=> irq_n_o);

    p_supply_drop_ends_r8: assert property (@(posedge clk) disable iff (rst)
        (!irq_n_o && !supply_ok_i) |=> irq_n_o);
endmodule

bind pwrfail_irq pwrfail_irq_chk #(.HOLD_CYC(HOLD_CYC)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .below_i     (below_i),
    .supply_ok_i (supply_ok_i),
    .irq_n_o     (irq_n_o),
    .tick        (tick)
);

// File: tb/tb_pwrfail_irq.sv
`timescale 1ns/1ps
module tb_pwrfail_irq;
    localparam int TICK = 8;
    localparam int HOLD = 40;
    localparam int NEED = 3;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic below = 1'b0;
    logic good = 1'b0;
    logic irq_n;

    int total = 0;
    int bad = 0;
    bit cmp_on = 1'b0;

    always #5 clk = ~clk;

    pwrfail_irq #(.TICK_DIV(TICK), .HOLD_CYC(HOLD), .NEED_SAMPLES(NEED)) dut (
        .clk (clk), .rst (rst), .below_i (below), .supply_ok_i (good), .irq_n_o (irq_n)
    );

    // Reference model written from the requirements.
    int m_ph, m_run, m_len;
    bit m_arm, m_act;
    always @(posedge clk) begin
        bit smp, fire, act_old;
        if (rst) begin
            m_ph = 0; m_run = 0; m_len = 0; m_arm = 1; m_act = 0;
        end else begin
            smp = (m_ph == TICK - 1);
            m_ph = smp ? 0 : m_ph + 1;
            act_old = m_act;
            fire = good && smp && below && (m_run == NEED - 1) && m_arm;
            if (act_old) begin
                if (!good || !below || m_len == HOLD - 1) m_act = 0;
                else m_len++;
            end else if (fire) begin
                m_act = 1; m_len = 0;
            end
            if (!good) m_run = 0;
            else if (smp) begin
                if (below) begin
                    if (fire) m_arm = 0;
                    if (m_run < NEED) m_run++;
                end else begin
                    m_run = 0; m_arm = 1;
                end
            end
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d t=%0t", req, act, exp, $time);
        end
    endtask

    always @(negedge clk) begin
        if (cmp_on) chk(irq_n == !m_act, "R3 model compare", irq_n, !m_act);
    end

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    // Steps until irq_n low or max cycles; returns cycles waited.
    task automatic wait_low(input int max, output int k);
        k = 0;
        do begin
            step(1);
            k++;
        end while (irq_n == 1'b1 && k < max);
    endtask

    task automatic count_low(input int n, output int lows);
        lows = 0;
        for (int i = 0; i < n; i++) begin
            step(1);
            if (irq_n == 1'b0) lows++;
        end
    endtask

    task automatic low_len(output int len);
        len = 0;
        while (irq_n == 1'b0 && len < 4 * HOLD) begin
            len++;
            step(1);
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        bad++;
        total++;
        $display("FAIL watchdog expired actual=1 expected=0");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        int k, n;
        int seed;
        step(3);
        chk(irq_n == 1'b1, "R1 reset idle", irq_n, 1);
        rst = 1'b0;
        step(1);
        chk(irq_n == 1'b1, "R1 after reset", irq_n, 1);

        // R10: healthy input at power-up
        good = 1'b1;
        count_low(200, n);
        chk(n == 0, "R10 no pulse with input above", n, 0);

        // R7: supply not good blocks detections
        good = 1'b0;
        below = 1'b1;
        count_low(200, n);
        chk(n == 0, "R7 blocked while supply bad", n, 0);
        good = 1'b1;
        wait_low(4 * TICK, k);
        chk(k >= 2 * TICK + 1 && k <= 3 * TICK, "R3 latency after supply good", k, 3 * TICK);
        chk(irq_n == 1'b0, "R2 pulse started", irq_n, 0);
        low_len(n);
        chk(n == HOLD, "R5 timeout length", n, HOLD);
        chk(n == HOLD, "R7 power-up pulse by timeout", n, HOLD);

        // R9: no retrigger while input stays low
        count_low(100, n);
        chk(n == 0, "R9 no retrigger while low", n, 0);
        below = 1'b0;
        step(TICK + 2);
        below = 1'b1;
        wait_low(4 * TICK, k);
        chk(irq_n == 1'b0, "R9 rearmed after high sample", irq_n, 0);

        // R6: early release on recovery
        step(5);
        below = 1'b0;
        step(1);
        chk(irq_n == 1'b1, "R6 release on recovery", irq_n, 1);

        // R4: short dips rejected
        step(20);
        n = 0;
        for (int i = 0; i < 10; i++) begin
            int c;
            below = 1'b1;
            count_low(2 * TICK - 1, c);
            n += c;
            below = 1'b0;
            count_low(TICK + 1, c);
            n += c;
        end
        chk(n == 0, "R4 noise dips rejected", n, 0);

        // R8: supply drop ends pulse
        below = 1'b1;
        wait_low(4 * TICK, k);
        chk(irq_n == 1'b0, "R8 pulse before drop", irq_n, 0);
        step(3);
        good = 1'b0;
        step(1);
        chk(irq_n == 1'b1, "R8 ended by supply drop", irq_n, 1);
        count_low(20, n);
        chk(n == 0, "R7 quiet while supply bad", n, 0);
        good = 1'b1;
        count_low(100, n);
        chk(n == 0, "R9 unarmed after supply return", n, 0);
        below = 1'b0;
        step(2 * TICK);

        // Random runs against the model
        seed = 7;
        void'($urandom(seed));
        cmp_on = 1'b1;
        for (int s = 0; s < 150; s++) begin
            below = ($urandom_range(0, 99) < 60);
            if ($urandom_range(0, 19) == 0) good = ~good;
            step($urandom_range(1, 90));
        end
        cmp_on = 1'b0;

        // R1: reset mid-pulse
        good = 1'b1;
        below = 1'b1;
        wait_low(4 * TICK, k);
        rst = 1'b1;
        step(1);
        chk(irq_n == 1'b1, "R1 reset clears pulse", irq_n, 1);
        rst = 1'b0;
        wait_low(4 * TICK, k);
        chk(k == NEED * TICK, "R2 first sample after reset", k, NEED * TICK);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule